// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

A 16-bit up-counter sits behind an 8-bit register bus. It has three count sources. In timer mode it counts internal instruction ticks, one every four system clocks. In synchronous counter mode it counts rising edges of an external clock input, which first passes through a two-flop synchronizer and an edge detector. In asynchronous counter mode, each rising edge of the external clock flips a toggle register in that clock's own domain, and every change of the toggle, once resynchronized, is one count. A prescaler divides the selected source by 1, 2, 4 or 8. The count wraps from 0xFFFF to 0x0000 and sets a sticky overflow flag.

When the wide-access bit is set, the high-byte address no longer reaches the live count and instead uses a shadow byte. A read of the low byte copies the live high byte into the shadow, so two byte reads always give a coherent 16-bit value. A write to the high byte only loads the shadow. A later low-byte write then loads all 16 bits at once. A low-byte write also restarts the prescaler chain.

Top module: `tmr16_buffered`

Register map: address 0 is control, 1 is the low count byte, 2 is the high count byte (or the shadow byte), and 3 is status. Control bits: [0] run, [1] external source, [2] asynchronous path, [4:3] prescale select, [7] wide access. Bits [6:5] read as 0.

## Requirements
- R1: After reset, all four addresses read 0x00 and ovf_flag is low.
- R2: Timer mode (ctrl[1]=0) with prescale select 0: the count advances once for every 4 system-clock edges that see run=1, counted from the low-byte write that last restarted the chain.
- R3: Prescale select s (ctrl[4:3]) divides the source by 2^s. M run edges in timer mode give floor(M/(4*2^s)) counts.
- R4: Synchronous counter mode (ctrl[1]=1, ctrl[2]=0) adds one count per rising edge of ext_clk, provided each level of ext_clk lasts several system clocks.
- R5: Asynchronous counter mode (ctrl[1]=1, ctrl[2]=1) adds one count per rising edge of ext_clk. This includes high pulses shorter than one system-clock period that no system-clock edge sees.
- R6: With ctrl[7]=1, a low-byte read copies the live high byte into the shadow. Address 2 then returns the shadow, even if the live high byte changes afterwards.
- R7: With ctrl[7]=1, a write to address 2 changes only the shadow and leaves the live high byte unchanged. A write to address 1 then loads the live count as {shadow, data}.
- R8: A write to address 1 restarts the prescaler chain. A write to address 2 does not.
- R9: With ctrl[7]=0, addresses 1 and 2 read and write the live low and high count bytes directly.
- R10: Wrapping from 0xFFFF to 0x0000 sets status bit 0 and ovf_flag. The flag stays set until a write to address 3 with data bit 0 = 1. Writing 0 to that bit leaves it set.
- R11: With run=0, the count and the prescaler hold their values, and register reads and writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| ext_clk | input | 1 | External count clock |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Timer counting is tried with all four prescale settings. Run windows are sized to land exactly on a count boundary, which separates a wrong divide ratio from an off-by-one in the instruction-tick divider. Slow, wide external pulses show that the synchronous path counts each rising edge once. Pulses of 3 ns, placed between system-clock edges, are counted only by the asynchronous toggle path, which separates the two counter modes. Random 16-bit values are written and read back with wide access both on and off, and directed sequences show that the shadow stays unchanged when the live high byte changes and that a prescaler remainder survives a high-byte write but not a low-byte write.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic       wide;
    logic [1:0] rsvd;
    logic [1:0] ps_sel;
    logic       async_sel;
    logic       ext_sel;
    logic       run;
  } ctrl_t;

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sr_d = {sr_q[STAGES-2:0], d};
    end else begin : g_single
      always_comb sr_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/tmr16_tick_src.sv
module tmr16_tick_src #(
  parameter int CYC_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic run,
  input  logic ext_sel,
  input  logic async_sel,
  input  logic clr,
  output logic tick
);

  localparam int DIV_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_DIV - 1);

  // Instruction-rate divider
  logic [DIV_W-1:0] div_q, div_d;
  logic             int_tick;

  assign int_tick = run && !ext_sel && (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    if (clr)                  div_d = '0;
    else if (run && !ext_sel) div_d = (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // Synchronous path: resync the level, then detect the rising edge
  logic ext_s, ext_prev_q, sync_rise;

  tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync_lvl (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_s;
  end

  assign sync_rise = ext_s && !ext_prev_q;

  // Asynchronous path: a toggle in the external domain, then resync of the change
  logic tog_q, tog_d, tog_s, tog_prev_q, async_evt;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync_tog (
    .clk(clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_prev_q <= 1'b0;
    else        tog_prev_q <= tog_s;
  end

  assign async_evt = tog_s ^ tog_prev_q;

  always_comb begin
    if (!run)          tick = 1'b0;
    else if (!ext_sel) tick = int_tick;
    else if (async_sel) tick = async_evt;
    else               tick = sync_rise;
  end

  generate
    if (CYC_DIV > 1) begin : g_gap_chk
      // R2: instruction ticks never come on back-to-back cycles
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);
    end
  endgenerate

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             inc
);

  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] pcnt_q, pcnt_d, mask;

  assign mask = PS_W'((1 << sel) - 1);
  assign inc  = tick && ((pcnt_q & mask) == mask);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (tick) pcnt_d = pcnt_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: with any ratio above 1, two consecutive outputs are impossible
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && sel != '0) |=> (!inc || sel == '0));

  // R11: with no source tick and no restart, the prescaler holds its state
  a_r11_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(pcnt_q));

endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered #(
  parameter int DW          = 8,
  parameter int CYC_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PS_SEL_W    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_clk,
  output logic          ovf_flag
);
  import tmr16_pkg::*;

  localparam int CNT_W = 2 * DW;

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]     shadow_q, shadow_d;
  logic              ovf_q, ovf_d;

  logic we_ctrl, we_lo, we_hi, we_st, rd_lo;
  logic hi_direct, wrap, tick, inc;

  assign we_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign we_lo     = bus_wr && (bus_addr == ADDR_LO);
  assign we_hi     = bus_wr && (bus_addr == ADDR_HI);
  assign we_st     = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_lo     = bus_rd && (bus_addr == ADDR_LO);
  assign hi_direct = we_hi && !ctrl_q.wide;

  tmr16_tick_src #(.CYC_DIV(CYC_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .run(ctrl_q.run), .ext_sel(ctrl_q.ext_sel), .async_sel(ctrl_q.async_sel),
    .clr(we_lo), .tick(tick)
  );

  tmr16_prescaler #(.SEL_W(PS_SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(we_lo),
    .sel(ctrl_q.ps_sel), .inc(inc)
  );

  assign wrap = inc && (cnt_q == {CNT_W{1'b1}}) && !we_lo && !hi_direct;

  // Next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (we_ctrl) begin
      ctrl_d      = ctrl_t'(bus_wdata);
      ctrl_d.rsvd = '0;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + CNT_W'(1);
    if (we_lo) begin
      if (ctrl_q.wide) cnt_d = {shadow_q, bus_wdata};
      else             cnt_d = {cnt_q[CNT_W-1:DW], bus_wdata};
    end
    if (hi_direct) cnt_d[CNT_W-1:DW] = bus_wdata;
  end

  always_comb begin
    shadow_d = shadow_q;
    if (we_hi && ctrl_q.wide)      shadow_d = bus_wdata;
    else if (rd_lo && ctrl_q.wide) shadow_d = cnt_q[CNT_W-1:DW];
  end

  always_comb begin
    ovf_d = ovf_q;
    if (we_st && bus_wdata[0]) ovf_d = 1'b0;
    if (wrap)                  ovf_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      shadow_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      ovf_q    <= ovf_d;
    end
  end

  // Read mux
  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_LO:   bus_rdata = cnt_q[DW-1:0];
      ADDR_HI:   bus_rdata = ctrl_q.wide ? shadow_q : cnt_q[CNT_W-1:DW];
      default:   bus_rdata = {{(DW-1){1'b0}}, ovf_q};
    endcase
  end

  assign ovf_flag = ovf_q;

  // R6: a wide low-byte read captures the high byte seen in that cycle
  a_r6_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && ctrl_q.wide) |=> (shadow_q == $past(cnt_q[CNT_W-1:DW])));

  // R7: a wide high-byte write leaves the live high byte alone
  a_r7_hi_write_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && ctrl_q.wide && !inc) |=> $stable(cnt_q[CNT_W-1:DW]));

  // R10: a wrap sets the flag and zeroes the count
  a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q == {CNT_W{1'b1}} && !bus_wr) |=> (ovf_q && cnt_q == '0));

  // R10: the flag stays set until software clears it
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(we_st && bus_wdata[0])) |=> ovf_q);

endmodule

// File: tb/tb_tmr16_buffered.sv
module tb_tmr16_buffered;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk, rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ext_clk, ovf_flag;

  int checks = 0;
  int fails  = 0;

  tmr16_buffered dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_counts(input int edges, input int sel);
    return edges / (DIV * (1 << sel));
  endfunction

  function automatic logic [7:0] ctrl_val(input bit run, input bit ext,
                                          input bit asy, input int sel, input bit wide);
    return {wide, 2'b00, 2'(sel), asy, ext, run};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // run=1 is seen by exactly m clock edges (m >= 2)
  task automatic run_for(input int m, input int sel);
    wr(2'd0, ctrl_val(1, 0, 0, sel, 0));
    repeat (m - 2) @(negedge clk);
    wr(2'd0, ctrl_val(0, 0, 0, sel, 0));
  endtask

  task automatic read16_narrow(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd2, h); rd(2'd1, l);
    v = {h, l};
  endtask

  task automatic set16_narrow(input logic [15:0] v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    void'($urandom(32'd4711));
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; ext_clk = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), b);
      chk("R1 reset read", {8'h00, b}, 16'h0000);
    end
    chk("R1 reset ovf_flag", {15'd0, ovf_flag}, 16'd0);

    // R2/R3: timer mode with every prescale value
    for (int s = 0; s < 4; s++) begin
      set16_narrow(16'h0000);
      run_for(DIV * (1 << s) * 5, s);
      read16_narrow(v);
      chk(s == 0 ? "R2 timer count" : "R3 prescaled count", v, 16'(exp_counts(DIV * (1 << s) * 5, s)));
    end
    // R2: a window one edge short of a boundary
    set16_narrow(16'h0000);
    run_for(4 * DIV - 1, 0);
    read16_narrow(v);
    chk("R2 partial window", v, 16'(exp_counts(4 * DIV - 1, 0)));

    // R8: a prescaler remainder survives a high-byte write
    set16_narrow(16'h0000);
    run_for(3 * DIV, 1);
    wr(2'd2, 8'h00);
    run_for(DIV, 1);
    read16_narrow(v);
    chk("R8 hi write keeps prescaler", v, 16'd2);
    // R8: a low-byte write discards it
    set16_narrow(16'h0000);
    run_for(3 * DIV, 1);
    wr(2'd1, 8'h01);
    run_for(DIV, 1);
    read16_narrow(v);
    chk("R8 lo write clears prescaler", v, 16'd1);

    // R11: frozen with run=0, even with external activity
    set16_narrow(16'h1234);
    wr(2'd0, ctrl_val(0, 1, 0, 0, 0));
    repeat (5) begin
      ext_clk = 1; repeat (4) @(negedge clk);
      ext_clk = 0; repeat (4) @(negedge clk);
    end
    read16_narrow(v);
    chk("R11 frozen count", v, 16'h1234);
    rd(2'd0, b);
    chk("R11 ctrl readback", {8'h00, b}, {8'h00, ctrl_val(0, 1, 0, 0, 0)});

    // R4: synchronous counter
    set16_narrow(16'h0000);
    wr(2'd0, ctrl_val(1, 1, 0, 0, 0));
    repeat (5) begin
      ext_clk = 1; repeat (4) @(negedge clk);
      ext_clk = 0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(2'd0, ctrl_val(0, 1, 0, 0, 0));
    read16_narrow(v);
    chk("R4 sync edge count", v, 16'd5);
    // R4 with R3: divide by 2 on external edges
    set16_narrow(16'h0000);
    wr(2'd0, ctrl_val(1, 1, 0, 1, 0));
    repeat (6) begin
      ext_clk = 1; repeat (4) @(negedge clk);
      ext_clk = 0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(2'd0, ctrl_val(0, 1, 0, 1, 0));
    read16_narrow(v);
    chk("R4 sync prescaled", v, 16'd3);

    // R5: asynchronous counter with short pulses between clock edges
    set16_narrow(16'h0000);
    wr(2'd0, ctrl_val(1, 1, 1, 0, 0));
    repeat (7) begin
      @(negedge clk);
      ext_clk = 1; #3; ext_clk = 0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(2'd0, ctrl_val(0, 1, 1, 0, 0));
    read16_narrow(v);
    chk("R5 async narrow pulses", v, 16'd7);

    // R6: shadow captured on wide low read, independent of later live change
    set16_narrow(16'h12AB);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 1));
    rd(2'd1, b);
    chk("R6 wide low read", {8'h00, b}, 16'h00AB);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 0));
    wr(2'd2, 8'h77);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 1));
    rd(2'd2, b);
    chk("R6 shadow holds", {8'h00, b}, 16'h0012);

    // R7: wide high write only buffers; low write commits both
    wr(2'd2, 8'h5A);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 0));
    rd(2'd2, b);
    chk("R7 live high untouched", {8'h00, b}, 16'h0077);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 1));
    wr(2'd1, 8'hC3);
    wr(2'd0, ctrl_val(0, 0, 0, 0, 0));
    read16_narrow(v);
    chk("R7 combined commit", v, 16'h5AC3);

    // R9 / R6 / R7: random round trips in both access modes (run=0, R11)
    for (int i = 0; i < 24; i++) begin
      logic [15:0] val;
      bit wide;
      logic [7:0] h, l;
      val  = 16'($urandom);
      wide = 1'($urandom);
      wr(2'd0, ctrl_val(0, 0, 0, 0, wide));
      if (wide) begin
        wr(2'd2, val[15:8]); wr(2'd1, val[7:0]);
        rd(2'd1, l); rd(2'd2, h);
      end else begin
        wr(2'd1, val[7:0]); wr(2'd2, val[15:8]);
        rd(2'd2, h); rd(2'd1, l);
      end
      chk(wide ? "R7 random wide round trip" : "R9 random direct round trip", {h, l}, val);
    end

    // R10: wrap sets a sticky flag; only writing 1 clears it
    wr(2'd0, ctrl_val(0, 0, 0, 0, 0));
    set16_narrow(16'hFFFE);
    run_for(2 * DIV, 0);
    read16_narrow(v);
    chk("R10 wrapped count", v, 16'h0000);
    rd(2'd3, b);
    chk("R10 flag set", {8'h00, b}, 16'h0001);
    chk("R10 ovf_flag pin", {15'd0, ovf_flag}, 16'd1);
    wr(2'd3, 8'h00);
    rd(2'd3, b);
    chk("R10 write 0 keeps flag", {8'h00, b}, 16'h0001);
    wr(2'd3, 8'h01);
    rd(2'd3, b);
    chk("R10 write 1 clears flag", {8'h00, b}, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule